// File: doc/BRIEF.md
# Predicate Register File with Instruction Gating

This block stores the one-bit condition flags that drive predicated execution. Every instruction presented to the issue port names a qualifying flag. The block looks that flag up and raises an execute-enable only when the flag is true. Downstream units use this enable to discard the results and side effects of instructions that are switched off. Entry 0 always reads true, so an instruction that should always run names entry 0.

A compare-result write port updates two flags in a single operation. The first destination receives the comparison outcome, and the second receives its inverse. The compare is itself qualified by a flag, so a chain of conditions can be evaluated with no branches. When the compare's qualifying flag is false, neither destination changes. The comparator that produces the outcome lies outside this block.

Top module: `pred_file`

## Requirements
- R1: After reset, entry 0 reads true and every other entry reads false.
- R2: `issue_en` is 1 exactly when `issue_valid` is 1 and the entry selected by `issue_qp` is true. It is 0 whenever `issue_valid` is 0.
- R3: Entry 0 always reads true. A compare that targets entry 0 leaves it true.
- R4: A compare whose qualifying entry is true writes `cmp_cond` to entry `cmp_dst_a` and the inverse of `cmp_cond` to entry `cmp_dst_b`. The new values are visible on the issue port in the next cycle.
- R5: A compare whose qualifying entry is false changes no entry.
- R6: When `cmp_dst_a` and `cmp_dst_b` name the same entry, that entry receives `cmp_cond`.
- R7: An issue lookup made in the same cycle as a compare that writes the looked-up entry returns the value from before the write.
- R8: A compare changes no entry other than its two destinations.
- R9: `cmp_taken` is 1 exactly when `cmp_valid` is 1 and the entry selected by `cmp_qp` is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_qp | input | IDXW | Qualifying flag index of the instruction |
| issue_en | output | 1 | Execute-enable for the instruction |
| cmp_valid | input | 1 | A compare result is presented this cycle |
| cmp_qp | input | IDXW | Qualifying flag index of the compare |
| cmp_dst_a | input | IDXW | Destination that receives the outcome |
| cmp_dst_b | input | IDXW | Destination that receives the inverted outcome |
| cmp_cond | input | 1 | Comparison outcome |
| cmp_taken | output | 1 | The compare was enabled and performed its writes |

## Verification
A flag stored with the wrong value shows up only when some later instruction or compare names it. At that point `issue_en` or `cmp_taken` carries the wrong value in the same cycle as the lookup. A wrong value in a compare's qualifying flag is worse, because the compare then writes or skips both of its destinations, and that error spreads through a chain of dependent compares. The reference model is therefore compared on both outputs in every cycle. Long random runs make most flags serve as lookups soon after they are written. A final sweep reads every entry, so that a stray write to an entry nobody names is also caught.

// File: rtl/pred_file.sv
module pred_file #(
  parameter int NUM_PRED = 64,
  localparam int IDXW = $clog2(NUM_PRED)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [IDXW-1:0] issue_qp,
  output logic            issue_en,
  input  logic            cmp_valid,
  input  logic [IDXW-1:0] cmp_qp,
  input  logic [IDXW-1:0] cmp_dst_a,
  input  logic [IDXW-1:0] cmp_dst_b,
  input  logic            cmp_cond,
  output logic            cmp_taken
);

  logic [NUM_PRED-1:0] pred_q, pred_d;

  assign issue_en  = issue_valid & pred_q[issue_qp];
  assign cmp_taken = cmp_valid & pred_q[cmp_qp];

  always_comb begin
    pred_d = pred_q;
    if (cmp_taken) begin
      pred_d[cmp_dst_b] = ~cmp_cond;
      pred_d[cmp_dst_a] = cmp_cond;
    end
    pred_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pred_q <= NUM_PRED'(1);
    else        pred_q <= pred_d;

  // R3
  p0_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_qp == '0 |-> issue_en);

  // R4
  dst_a_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_taken && cmp_dst_a != '0 |=> pred_q[$past(cmp_dst_a)] == $past(cmp_cond));

  // R4
  dst_b_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_taken && cmp_dst_b != '0 && cmp_dst_b != cmp_dst_a
    |=> pred_q[$past(cmp_dst_b)] == !$past(cmp_cond));

  // R5
  gated_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_taken |=> $stable(pred_q));

  // R2
  idle_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> !issue_en);

endmodule

// File: tb/pred_file_bench.sv
module pred_file_bench;
  localparam int N = 64;
  localparam int W = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic issue_valid = 0, cmp_valid = 0, cmp_cond = 0;
  logic [W-1:0] issue_qp = 0, cmp_qp = 0, cmp_dst_a = 0, cmp_dst_b = 0;
  logic issue_en, cmp_taken;

  bit mdl [N];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pred_file u_pred_file (.*);

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic iv, int iq, logic cv, int cq, int a, int b, logic c,
                      string tag_en, string tag_tk);
    logic exp_en, exp_tk;
    issue_valid = iv; issue_qp = W'(iq);
    cmp_valid = cv; cmp_qp = W'(cq); cmp_dst_a = W'(a); cmp_dst_b = W'(b); cmp_cond = c;
    #1;
    exp_en = iv && mdl[iq];
    exp_tk = cv && mdl[cq];
    chk(tag_en, issue_en, exp_en);
    chk(tag_tk, cmp_taken, exp_tk);
    @(posedge clk);
    if (exp_tk) begin
      if (b != 0) mdl[b] = !c;
      if (a != 0) mdl[a] = c;
    end
    @(negedge clk);
  endtask

  task automatic rd(int k, string tag);
    step(1, k, 0, 0, 0, 0, 0, tag, "R9");
  endtask

  initial begin
    for (int k = 0; k < N; k++) mdl[k] = (k == 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R3 entry 0
    for (int k = 0; k < N; k++) rd(k, k == 0 ? "R3" : "R1");
    // R2 idle issue
    step(0, 0, 0, 0, 0, 0, 0, "R2", "R9");
    // R4 and R7: write 5=1, 9=0, reading 5 in the same cycle returns old
    step(1, 5, 1, 0, 5, 9, 1, "R7", "R9");
    rd(5, "R4"); rd(9, "R4");
    step(1, 9, 1, 0, 5, 9, 0, "R7", "R9");
    rd(5, "R4"); rd(9, "R4");
    // R5 gated compare: qp 12 false
    step(1, 12, 1, 12, 5, 9, 0, "R2", "R9");
    rd(5, "R5"); rd(9, "R5");
    // R3 write to entry 0
    step(1, 0, 1, 0, 0, 40, 0, "R3", "R9");
    rd(0, "R3"); rd(40, "R4");
    // R6 same destination
    step(1, 20, 1, 0, 20, 20, 1, "R7", "R9");
    rd(20, "R6");
    step(1, 20, 1, 9, 20, 20, 0, "R2", "R9");
    rd(20, "R6");
    // chained compare qualified by entry 9 (true)
    step(1, 30, 1, 9, 30, 31, 1, "R2", "R9");
    rd(30, "R4"); rd(31, "R4");
    // random traffic
    for (int i = 0; i < 3000; i++)
      step($urandom_range(1, 0), $urandom_range(N - 1, 0),
           $urandom_range(1, 0), $urandom_range(7, 0) == 0 ? 0 : $urandom_range(N - 1, 0),
           $urandom_range(N - 1, 0), $urandom_range(N - 1, 0), $urandom_range(1, 0),
           "R2", "R9");
    // R8 full sweep
    for (int k = 0; k < N; k++) rd(k, "R8");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule